// File: doc/BRIEF.md
# Maskable Interrupt Controller with Enable Save Stack

This block sits beside a small processor core and decides when the core takes an interrupt. It watches one non-maskable request and five maskable sources: a receiver request, a transmit-FIFO-empty flag, a line-turnaround flag, a bidirectional-I/O request line and a timer-expiry flag. Each maskable source passes through its own mask bit and then through a single master enable. When a request wins, the block raises a one-cycle `irq_take` pulse with a vector code. It clears the master enable and stores the enable's previous value beside the core's return address on a four-entry stack.

The core tells the block when it runs a return or a bank exchange. Each carries a 2-bit option that adjusts the master enable. A return pops the stack, and its option may put back the enable value that was saved when the interrupt was taken. The receiver request comes from one of four selectable receiver conditions. The event flags set and clear on strobes from the transceiver, the timer and the core's register writes.

All pins are plain control and status signals. There is no streamed data path, so the block applies no valid/ready back-pressure. `ret_valid` and `xch_valid` are one-cycle strobes that the block always accepts.

Top module: `intc_core`

## Requirements
- R1: After reset, `mask_q` is 5'b11111, `en_q` is 0, `stk_depth` is 0, `irq_take` is 0, and the transmit-empty flag (`pend_q[1]`) reads 1.
- R2: Mask bit i gates source i, where 0 is receiver, 1 is transmit-empty, 2 is line-turnaround, 3 is I/O request and 4 is timer. A mask bit of 1 blocks its source and 0 enables it. `pend_q[i]` shows the raw request of source i, and `mask_wr` loads `mask_wdata` on the next edge.
- R3: Maskable sources are taken only while `en_q` is 1. A rising edge on `nmi_in` is latched and taken whatever the value of `en_q`, once per edge. The latch clears when the request is taken.
- R4: Fixed priority applies: the non-maskable request first, then sources 0 through 4 in ascending order. `irq_vec` is 0 for the non-maskable request and i+1 for source i.
- R5: In a cycle with `irq_take` high, the master enable is cleared at the next edge. The pair {`en_q`, `pc_in`} is pushed onto the stack at that edge.
- R6: `ret_valid` pops the stack. During that cycle `ret_addr`/`ret_en` show the top entry. `ret_opt` sets the master enable: 0 keep, 1 clear, 2 set, 3 load the popped `ret_en`.
- R7: `xch_valid` with `xch_opt` changes the master enable: 1 clears it, 2 sets it, 0 and 3 leave it unchanged.
- R8: `rx_sel` picks the receiver request: 0 is `rx_full`, 1 is `rx_avail`, 2 is `rx_err` or `rx_full`, 3 is `rx_err` or `rx_avail`.
- R9: The transmit-empty flag is set by `xcvr_reset` or `tfe_set` and cleared by `tx_wr`. The line-turnaround flag is set by `lta_set` and cleared by `tx_wr` or `xcvr_reset`. When a set and a clear arrive in the same cycle, the set wins.
- R10: The timer flag is set by `tmr_exp` and cleared by `tmr_ack` or `tmr_stop`. When a set and a clear arrive in the same cycle, the set wins.
- R11: The stack holds 4 entries. A push while full overwrites the oldest entry. A pop while empty shows `ret_addr` 0 and `ret_en` 0 and leaves the depth at 0.
- R12: No interrupt is taken in a cycle with `ret_valid` or `xch_valid` high. If both are high, the return option wins. Either one takes precedence over `en_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_in | input | 1 | Non-maskable request, edge-latched |
| rx_full | input | 1 | Receiver FIFO full condition |
| rx_avail | input | 1 | Receiver data available condition |
| rx_err | input | 1 | Receiver error condition |
| rx_sel | input | 2 | Receiver request source select |
| xcvr_reset | input | 1 | Transceiver reset strobe |
| tfe_set | input | 1 | Transmit FIFO became empty |
| tx_wr | input | 1 | Write to the transmit data register |
| lta_set | input | 1 | Line-turnaround event |
| bio_req | input | 1 | Bidirectional I/O request level |
| tmr_exp | input | 1 | Timer expiry strobe |
| tmr_ack | input | 1 | Timer flag acknowledge write |
| tmr_stop | input | 1 | Timer stopped |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 5 | Mask register write data |
| en_wr | input | 1 | Master enable write strobe |
| en_wdata | input | 1 | Master enable write data |
| ret_valid | input | 1 | Return operation strobe |
| ret_opt | input | 2 | Return enable option |
| xch_valid | input | 1 | Bank exchange strobe |
| xch_opt | input | 2 | Bank exchange enable option |
| pc_in | input | AW | Return address to save |
| irq_take | output | 1 | Interrupt recognized pulse |
| irq_vec | output | 3 | Vector code of the taken request |
| mask_q | output | 5 | Mask register |
| en_q | output | 1 | Master enable |
| pend_q | output | 5 | Raw maskable requests |
| ret_addr | output | AW | Top-of-stack return address |
| ret_en | output | 1 | Top-of-stack saved enable |
| stk_depth | output | 3 | Stack entries in use |

## Verification
The hardest state to reach is a full stack with a fifth entry overwriting the oldest one. Getting there needs five nested recognitions without a return. The bench produces them with a series of non-maskable edges while every mask bit is set. Before every other edge it sets the enable, so the saved enable values alternate. It then pops past empty and checks the address and enable order. A second hard case is a restore return re-taking a source that is still pending on the very next cycle. The bench pre-loads the scoreboard queue with both expected vectors before it issues the return.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NSRC = 5;
  localparam int VW   = $clog2(NSRC + 1);

  typedef enum logic [1:0] {
    OPT_KEEP    = 2'd0,
    OPT_CLR     = 2'd1,
    OPT_SET     = 2'd2,
    OPT_RESTORE = 2'd3
  } en_opt_t;

  typedef enum logic [1:0] {
    RXS_FULL      = 2'd0,
    RXS_AVAIL     = 2'd1,
    RXS_ERR_FULL  = 2'd2,
    RXS_ERR_AVAIL = 2'd3
  } rx_sel_t;

  localparam int SRC_RX  = 0;
  localparam int SRC_TFE = 1;
  localparam int SRC_LTA = 2;
  localparam int SRC_BIO = 3;
  localparam int SRC_TMR = 4;
endpackage

// File: rtl/intc_src.sv
module intc_src
  import intc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nmi_in,
  input  logic            clr_nmi,
  input  logic            rx_full,
  input  logic            rx_avail,
  input  logic            rx_err,
  input  logic [1:0]      rx_sel,
  input  logic            xcvr_reset,
  input  logic            tfe_set,
  input  logic            tx_wr,
  input  logic            lta_set,
  input  logic            bio_req,
  input  logic            tmr_exp,
  input  logic            tmr_ack,
  input  logic            tmr_stop,
  output logic            nmi_pend,
  output logic [NSRC-1:0] req
);
  logic nmi_prev;
  logic nmi_rise;
  logic tfe_q, lta_q, tmr_q;
  logic rx_req;

  assign nmi_rise = nmi_in & ~nmi_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_prev <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_prev <= nmi_in;
      nmi_pend <= (nmi_pend & ~clr_nmi) | nmi_rise;
    end
  end

  always_comb begin
    unique case (rx_sel_t'(rx_sel))
      RXS_FULL:      rx_req = rx_full;
      RXS_AVAIL:     rx_req = rx_avail;
      RXS_ERR_FULL:  rx_req = rx_err | rx_full;
      RXS_ERR_AVAIL: rx_req = rx_err | rx_avail;
      default:       rx_req = 1'b0;
    endcase
  end

  // Event flags: a set strobe outranks a clear strobe in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tfe_q <= 1'b1;
      lta_q <= 1'b0;
      tmr_q <= 1'b0;
    end else begin
      if (xcvr_reset || tfe_set) tfe_q <= 1'b1;
      else if (tx_wr)            tfe_q <= 1'b0;
      if (lta_set)                    lta_q <= 1'b1;
      else if (tx_wr || xcvr_reset)   lta_q <= 1'b0;
      if (tmr_exp)                    tmr_q <= 1'b1;
      else if (tmr_ack || tmr_stop)   tmr_q <= 1'b0;
    end
  end

  always_comb begin
    req          = '0;
    req[SRC_RX]  = rx_req;
    req[SRC_TFE] = tfe_q;
    req[SRC_LTA] = lta_q;
    req[SRC_BIO] = bio_req;
    req[SRC_TMR] = tmr_q;
  end

  a_r3_nmi_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_nmi && !nmi_rise) |=> !nmi_pend);
  a_r10_tmr_set: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_exp |=> req[SRC_TMR]);
  a_r9_tfe_set: assert property (@(posedge clk) disable iff (!rst_n)
    xcvr_reset |=> (req[SRC_TFE] && !$past(lta_set) |-> !req[SRC_LTA]));
endmodule

// File: rtl/intc_prio.sv
module intc_prio
  import intc_pkg::*;
(
  input  logic            nmi_pend,
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] mask,
  input  logic            en,
  input  logic            hold,
  output logic            take,
  output logic [VW-1:0]   vec
);
  logic [NSRC-1:0] live;
  logic            any_live;
  logic [VW-1:0]   low_idx;

  assign live     = req & ~mask & {NSRC{en}};
  assign any_live = |live;

  // Scan from the top so the lowest index is written last and wins.
  always_comb begin
    low_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (live[i]) low_idx = VW'(i + 1);
    end
  end

  assign take = !hold && (nmi_pend || any_live);
  assign vec  = nmi_pend ? '0 : low_idx;
endmodule

// File: rtl/intc_en_stack.sv
module intc_en_stack #(
  parameter int AW    = 16,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic          push_en,
  input  logic          pop,
  output logic [AW-1:0] top_addr,
  output logic          top_en,
  output logic [CW-1:0] depth
);
  logic [AW-1:0] addr_mem [DEPTH];
  logic          en_mem   [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] top_idx;
  logic [PW-1:0] nxt_idx;
  logic          empty;
  logic          full;

  assign top_idx = (wr_ptr == '0) ? PW'(DEPTH - 1) : wr_ptr - PW'(1);
  assign nxt_idx = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
  assign empty   = (depth == '0);
  assign full    = (depth == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      depth  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        addr_mem[i] <= '0;
        en_mem[i]   <= 1'b0;
      end
    end else if (push) begin
      addr_mem[wr_ptr] <= push_addr;
      en_mem[wr_ptr]   <= push_en;
      wr_ptr           <= nxt_idx;
      if (!full) depth <= depth + CW'(1);
    end else if (pop && !empty) begin
      wr_ptr <= top_idx;
      depth  <= depth - CW'(1);
    end
  end

  assign top_addr = empty ? '0 : addr_mem[top_idx];
  assign top_en   = empty ? 1'b0 : en_mem[top_idx];

  a_r11_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CW'(DEPTH));
  a_r11_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty) |-> (!top_en && top_addr == '0) ##1 empty);
  a_r11_full_push: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> full);
endmodule

// File: rtl/intc_core.sv
module intc_core
  import intc_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nmi_in,
  input  logic          rx_full,
  input  logic          rx_avail,
  input  logic          rx_err,
  input  logic [1:0]    rx_sel,
  input  logic          xcvr_reset,
  input  logic          tfe_set,
  input  logic          tx_wr,
  input  logic          lta_set,
  input  logic          bio_req,
  input  logic          tmr_exp,
  input  logic          tmr_ack,
  input  logic          tmr_stop,
  input  logic          mask_wr,
  input  logic [4:0]    mask_wdata,
  input  logic          en_wr,
  input  logic          en_wdata,
  input  logic          ret_valid,
  input  logic [1:0]    ret_opt,
  input  logic          xch_valid,
  input  logic [1:0]    xch_opt,
  input  logic [AW-1:0] pc_in,
  output logic          irq_take,
  output logic [2:0]    irq_vec,
  output logic [4:0]    mask_q,
  output logic          en_q,
  output logic [4:0]    pend_q,
  output logic [AW-1:0] ret_addr,
  output logic          ret_en,
  output logic [2:0]    stk_depth
);
  logic            nmi_pend;
  logic [NSRC-1:0] req;
  logic            take;
  logic [VW-1:0]   vec;
  logic            hold;
  logic [CW-1:0]   depth;
  logic            en_n;

  assign hold = ret_valid | xch_valid;

  intc_src u_src (
    .clk, .rst_n, .nmi_in,
    .clr_nmi    (take && vec == '0),
    .rx_full, .rx_avail, .rx_err, .rx_sel,
    .xcvr_reset, .tfe_set, .tx_wr, .lta_set, .bio_req,
    .tmr_exp, .tmr_ack, .tmr_stop,
    .nmi_pend, .req
  );

  intc_prio u_prio (
    .nmi_pend, .req,
    .mask (mask_q),
    .en   (en_q),
    .hold,
    .take, .vec
  );

  intc_en_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk, .rst_n,
    .push      (take),
    .push_addr (pc_in),
    .push_en   (en_q),
    .pop       (ret_valid),
    .top_addr  (ret_addr),
    .top_en    (ret_en),
    .depth
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_wr) mask_q <= mask_wdata;
  end

  // Precedence: recognition, return, exchange, plain write.
  always_comb begin
    en_n = en_q;
    if (take) begin
      en_n = 1'b0;
    end else if (ret_valid) begin
      unique case (en_opt_t'(ret_opt))
        OPT_KEEP:    en_n = en_q;
        OPT_CLR:     en_n = 1'b0;
        OPT_SET:     en_n = 1'b1;
        OPT_RESTORE: en_n = ret_en;
        default:     en_n = en_q;
      endcase
    end else if (xch_valid) begin
      unique case (en_opt_t'(xch_opt))
        OPT_CLR: en_n = 1'b0;
        OPT_SET: en_n = 1'b1;
        default: en_n = en_q;
      endcase
    end else if (en_wr) begin
      en_n = en_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_n;
  end

  assign irq_take  = take;
  assign irq_vec   = 3'(vec);
  assign pend_q    = req;
  assign stk_depth = 3'(depth);

  a_r2_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && irq_vec != 3'd0) |-> !mask_q[irq_vec - 3'd1]);
  a_r3_en_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && irq_vec != 3'd0) |-> en_q);
  a_r5_en_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !en_q);
  a_r12_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid || xch_valid) |-> !irq_take);
  a_r4_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> irq_vec <= 3'(NSRC));
endmodule

// File: tb/intc_core_test.sv
module intc_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_in = 0, rx_full = 0, rx_avail = 0, rx_err = 0;
  logic [1:0] rx_sel = 0;
  logic xcvr_reset = 0, tfe_set = 0, tx_wr = 0, lta_set = 0, bio_req = 0;
  logic tmr_exp = 0, tmr_ack = 0, tmr_stop = 0;
  logic mask_wr = 0; logic [4:0] mask_wdata = 0;
  logic en_wr = 0, en_wdata = 0;
  logic ret_valid = 0; logic [1:0] ret_opt = 0;
  logic xch_valid = 0; logic [1:0] xch_opt = 0;
  logic [15:0] pc_in = 0;
  logic irq_take; logic [2:0] irq_vec; logic [4:0] mask_q; logic en_q;
  logic [4:0] pend_q; logic [15:0] ret_addr; logic ret_en; logic [2:0] stk_depth;

  int n_checks = 0;
  int n_fails  = 0;
  int exp_q[$];
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  intc_core uut (.*);

  task automatic check(string rq, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic set_mask(logic [4:0] m);
    mask_wr = 1; mask_wdata = m; tick(); mask_wr = 0;
  endtask

  task automatic set_en(logic v);
    en_wr = 1; en_wdata = v; tick(); en_wr = 0;
  endtask

  task automatic do_ret(logic [1:0] o, int ea, int ee);
    ret_valid = 1; ret_opt = o;
    @(negedge clk);
    check("R6 ret_addr", int'(ret_addr), ea);
    check("R6 ret_en", int'(ret_en), ee);
    check("R12 no take on ret", int'(irq_take), 0);
    tick(); ret_valid = 0;
  endtask

  task automatic do_xch(logic [1:0] o);
    xch_valid = 1; xch_opt = o;
    @(negedge clk);
    check("R12 no take on xch", int'(irq_take), 0);
    tick(); xch_valid = 0;
  endtask

  task automatic nmi_pulse(int addr);
    pc_in = 16'(addr); nmi_in = 1; tick(); nmi_in = 0; tick();
  endtask

  // Scoreboard monitor: every recognition must match the next queued vector.
  always @(negedge clk) begin
    if (rst_n && irq_take) begin
      if (exp_q.size() == 0) check("R3/R4 unexpected take", int'(irq_vec), -1);
      else check("R4 vector", int'(irq_vec), exp_q.pop_front());
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_fails++; n_checks++;
      $display("FAIL watchdog actual %0d expected %0d", WD_CYCLES, 0);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    @(negedge clk);
    check("R1 mask", int'(mask_q), 31);
    check("R1 en", int'(en_q), 0);
    check("R1 depth", int'(stk_depth), 0);
    check("R1 take", int'(irq_take), 0);
    check("R1 tfe flag", int'(pend_q[1]), 1);
    tick();

    // R9 / R10 flags
    lta_set = 1; tick(); lta_set = 0;
    @(negedge clk); check("R9 lta set", int'(pend_q[2]), 1); tick();
    tx_wr = 1; tick(); tx_wr = 0;
    @(negedge clk); check("R9 tfe clr", int'(pend_q[1]), 0);
    check("R9 lta clr by tx_wr", int'(pend_q[2]), 0); tick();
    lta_set = 1; tick(); lta_set = 0;
    xcvr_reset = 1; tick(); xcvr_reset = 0;
    @(negedge clk); check("R9 tfe set by xcvr_reset", int'(pend_q[1]), 1);
    check("R9 lta clr by xcvr_reset", int'(pend_q[2]), 0); tick();
    tx_wr = 1; tick(); tx_wr = 0;
    tx_wr = 1; tfe_set = 1; tick(); tx_wr = 0; tfe_set = 0;
    @(negedge clk); check("R9 set wins", int'(pend_q[1]), 1); tick();
    tx_wr = 1; tick(); tx_wr = 0;
    tmr_exp = 1; tick(); tmr_exp = 0;
    @(negedge clk); check("R10 tmr set", int'(pend_q[4]), 1); tick();
    tmr_ack = 1; tick(); tmr_ack = 0;
    @(negedge clk); check("R10 tmr ack", int'(pend_q[4]), 0); tick();
    tmr_exp = 1; tick(); tmr_exp = 0;
    tmr_stop = 1; tmr_exp = 1; tick(); tmr_stop = 0; tmr_exp = 0;
    @(negedge clk); check("R10 set wins", int'(pend_q[4]), 1); tick();
    tmr_stop = 1; tick(); tmr_stop = 0;
    @(negedge clk); check("R10 tmr stop", int'(pend_q[4]), 0); tick();

    // R8 receiver select table
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 8; c++) begin
        bit f, a, e, want;
        f = c[0]; a = c[1]; e = c[2];
        rx_sel = 2'(s); rx_full = f; rx_avail = a; rx_err = e;
        want = (s == 0) ? f : (s == 1) ? a : (s == 2) ? (e | f) : (e | a);
        @(negedge clk); check("R8 rx select", int'(pend_q[0]), int'(want));
        tick();
      end
    end
    rx_full = 0; rx_avail = 0; rx_err = 0; rx_sel = 0;

    // R3 NMI with enable clear, R6 restore
    exp_q.push_back(0);
    nmi_pulse(16'h0040);
    @(negedge clk); check("R5 en after nmi", int'(en_q), 0);
    check("R5 depth", int'(stk_depth), 1); tick();
    do_ret(2'd3, 16'h0040, 0);
    @(negedge clk); check("R6 restore 0", int'(en_q), 0);
    check("R6 depth", int'(stk_depth), 0); tick();

    // R2 / R5 / R6: unmask transmit-empty
    tfe_set = 1; tick(); tfe_set = 0;
    set_en(1);
    exp_q.push_back(2);
    pc_in = 16'h0100;
    set_mask(5'b11101);
    tick();
    @(negedge clk); check("R5 en cleared", int'(en_q), 0);
    check("R2 mask_q", int'(mask_q), 29); tick();
    exp_q.push_back(2);
    pc_in = 16'h0104;
    do_ret(2'd3, 16'h0100, 1);
    tick();
    @(negedge clk); check("R5 en after retake", int'(en_q), 0);
    check("R5 depth", int'(stk_depth), 1); tick();
    tx_wr = 1; tick(); tx_wr = 0;
    do_ret(2'd0, 16'h0104, 1);
    @(negedge clk); check("R6 keep", int'(en_q), 0); tick();
    set_mask(5'b11111);

    // R4 priority among maskables
    lta_set = 1; tmr_exp = 1; bio_req = 1; tick(); lta_set = 0; tmr_exp = 0;
    set_en(1);
    exp_q.push_back(3); pc_in = 16'h0200;
    set_mask(5'b00000);
    tick();
    tx_wr = 1; tick(); tx_wr = 0;
    exp_q.push_back(4); pc_in = 16'h0210;
    do_ret(2'd2, 16'h0200, 1);
    tick();
    bio_req = 0;
    exp_q.push_back(5); pc_in = 16'h0220;
    do_ret(2'd2, 16'h0210, 1);
    tick();
    tmr_ack = 1; tick(); tmr_ack = 0;
    do_ret(2'd1, 16'h0220, 1);
    @(negedge clk); check("R6 clear", int'(en_q), 0); tick();

    // R4 non-maskable first
    exp_q.push_back(0); exp_q.push_back(4);
    bio_req = 1; en_wr = 1; en_wdata = 1; nmi_in = 1; pc_in = 16'h0300;
    tick(); en_wr = 0; nmi_in = 0;
    tick();
    pc_in = 16'h0310;
    do_ret(2'd3, 16'h0300, 1);
    tick();
    bio_req = 0;
    do_ret(2'd1, 16'h0310, 1);
    set_mask(5'b11111);

    // R8 receiver take
    set_mask(5'b11110);
    rx_sel = 2'd1; rx_avail = 1;
    exp_q.push_back(1); pc_in = 16'h0400;
    set_en(1);
    tick();
    rx_avail = 0;
    do_ret(2'd1, 16'h0400, 1);
    set_mask(5'b11111);

    // R7 exchange options
    do_xch(2'd2); @(negedge clk); check("R7 set", int'(en_q), 1); tick();
    do_xch(2'd0); @(negedge clk); check("R7 keep", int'(en_q), 1); tick();
    do_xch(2'd1); @(negedge clk); check("R7 clear", int'(en_q), 0); tick();
    do_xch(2'd3); @(negedge clk); check("R7 opt3 keep", int'(en_q), 0); tick();

    // R12 ret beats xch; xch holds off a pending take
    ret_valid = 1; ret_opt = 2'd2; xch_valid = 1; xch_opt = 2'd1;
    tick(); ret_valid = 0; xch_valid = 0;
    @(negedge clk); check("R12 ret wins", int'(en_q), 1);
    check("R11 empty pop depth", int'(stk_depth), 0); tick();
    set_en(0);
    tmr_exp = 1; tick(); tmr_exp = 0;
    set_mask(5'b01111);
    exp_q.push_back(5); pc_in = 16'h0500;
    do_xch(2'd2);
    tick();
    tmr_ack = 1; tick(); tmr_ack = 0;
    do_ret(2'd1, 16'h0500, 1);
    set_mask(5'b11111);

    // R11 overflow and empty pop
    for (int k = 0; k < 5; k++) begin
      if (k % 2 == 0) set_en(1);
      exp_q.push_back(0);
      nmi_pulse(16'h0600 + k);
    end
    @(negedge clk); check("R11 depth full", int'(stk_depth), 4); tick();
    for (int k = 4; k >= 1; k--) do_ret(2'd0, 16'h0600 + k, (k % 2 == 0) ? 1 : 0);
    do_ret(2'd0, 0, 0);
    @(negedge clk); check("R11 depth empty", int'(stk_depth), 0);
    check("R3 queue drained", exp_q.size(), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule